// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Controller

This block is the control front end of a pipelined synchronous static RAM, carrying its own small storage array so that it runs stand-alone in simulation. Every address, control and write-data input is captured in an input register on the rising clock edge. The registered command executes on the following edge: a write updates the array, and a read loads the addressed word into an output register. Read data therefore appears on the data outputs a fixed two edges after the address was presented.

Each data word is split into byte lanes of 8 data bits plus one parity bit. A lane is written when the byte-write enable and that lane's select are both high. A global write overrides the lane selects and writes every lane. Three chip selects with mixed polarity must all be active for a cycle to count as an access. A deselected cycle does nothing and leaves the outputs floating. An asynchronous active-low output enable floats the outputs at once. The first read after a deselected cycle is never driven, whatever the output enable says, so a bank joining a shared bus cannot drive it on its first read.

Top module: `pipe_sram`

## Requirements
- R1: With `glob_wr` low and `lane_wr_en` high, lane i is written from `wdata` only when `lane_sel[i]` is high. Lane 0 is bits [8:0] and lane 1 is bits [17:9]. An unselected lane keeps its old content. With `glob_wr` and `lane_wr_en` both low, the cycle is a read.
- R2: A selected read presented before rising edge k drives the addressed word on `dq` from just after edge k+1 until edge k+2. This holds when the previous cycle was selected and `oe_n` is low.
- R3: An access takes place only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. Any other combination writes nothing, and `dq` is high impedance in the cycle after that command executes.
- R4: With `glob_wr` high, all lanes are written, whatever `lane_wr_en` and `lane_sel` are.
- R5: `oe_n` high puts `dq` into high impedance at once, with no clock edge. `oe_n` low lets registered read data show at once.
- R6: A read whose previous cycle was deselected (or the first cycle after reset) does not drive `dq`. A read that directly follows a selected cycle is driven.
- R7: A write cycle never drives `dq` in the cycle after it executes.
- R8: While `rst_n` is low and after its release, `dq` is high impedance until a read is driven. The cycle before the first captured command counts as deselected.
- R9: A read of an address written in the immediately preceding cycle returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| glob_wr | input | 1 | Write all lanes |
| lane_wr_en | input | 1 | Enable lane-selective writes |
| lane_sel | input | LANES | Per-lane write select |
| wdata | input | LANES*(LANE_DW+1) | Write word |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | output | LANES*(LANE_DW+1) | Read data, high impedance when not driven |

## Verification
The bench builds the block with its default parameters: a 6-bit address (64 words) and two 9-bit lanes. This depth is small enough to fill every word with known data first, so every later read compares against a fully known reference. With two lanes, all four select patterns can be tried, and each one leaves a visibly different lane mix. The sequences cover each of the three chip selects dropped alone, a read directly after a deselect and after a write, and read-after-write on one address. They also cover `oe_n` toggled in the middle of a cycle, followed by a long random mix.

// File: rtl/pipe_sram_pkg.sv
// Shared types for the pipelined SRAM controller.
package pipe_sram_pkg;
    // Command held in the input register and executed one edge later.
    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } sram_op_e;
endpackage

// File: rtl/pipe_sram_capture.sv
// Input register stage: samples address, controls and write data on the
// rising edge and decodes them into an operation and per-lane write enables.
// Assumes the inputs are stable around the rising edge; reset yields OP_NOP.
module pipe_sram_capture
    import pipe_sram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 2,
    parameter int LANE_W  = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    chip_on,
    input  logic                    glob_wr,
    input  logic                    lane_wr_en,
    input  logic [LANES-1:0]        lane_sel,
    input  logic [LANES*LANE_W-1:0] wdata,
    output sram_op_e                op_q,
    output logic [ADDR_W-1:0]       addr_q,
    output logic [LANES*LANE_W-1:0] wdata_q,
    output logic [LANES-1:0]        lane_we_q
);
    sram_op_e         op_d;
    logic [LANES-1:0] lane_we_d;

    // Decode the raw controls into an operation and lane enables.
    always_comb begin
        lane_we_d = '0;
        if (!chip_on) begin
            op_d = OP_NOP;
        end else if (glob_wr || lane_wr_en) begin
            op_d      = OP_WRITE;
            lane_we_d = glob_wr ? {LANES{1'b1}} : lane_sel;
        end else begin
            op_d = OP_READ;
        end
    end

    // Input register; reset forces a no-operation command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_NOP;
            addr_q    <= '0;
            wdata_q   <= '0;
            lane_we_q <= '0;
        end else begin
            op_q      <= op_d;
            addr_q    <= addr;
            wdata_q   <= wdata;
            lane_we_q <= lane_we_d;
        end
    end

    AST_NOP_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q != OP_WRITE) |-> (lane_we_q == '0)); // R3
endmodule

// File: rtl/pipe_sram_array.sv
// Storage array split into independent byte lanes, one generated memory per
// lane. Writes happen on the edge that executes a registered write command;
// the read port is asynchronous and is sampled by the output stage.
// Assumes the array content is unknown until written (no reset of storage).
module pipe_sram_array
    import pipe_sram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 2,
    parameter int LANE_W  = 9
) (
    input  logic                    clk,
    input  sram_op_e                op,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [LANES-1:0]        lane_we,
    output logic [LANES*LANE_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        // Write this lane when the executing write selects it.
        always_ff @(posedge clk) begin
            if (op == OP_WRITE && lane_we[g]) begin
                store[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        // Asynchronous read of this lane.
        assign rd_word[g*LANE_W +: LANE_W] = store[addr];
    end
endmodule

// File: rtl/pipe_sram_outreg.sv
// Output register stage: captures read data when a registered read executes
// and decides whether the result may be driven. A read that directly follows
// a deselected cycle (or reset) is captured but never driven.
// Assumes op is the command currently held in the input register.
module pipe_sram_outreg
    import pipe_sram_pkg::*;
#(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sram_op_e          op,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] data_q,
    output logic              drive_q
);
    logic idle_before;

    // Output data register, loaded only by executing reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (op == OP_READ) begin
            data_q <= rd_word;
        end
    end

    // Drive decision and memory of whether the previous cycle was deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_q     <= 1'b0;
            idle_before <= 1'b1;
        end else begin
            drive_q     <= (op == OP_READ) && !idle_before;
            idle_before <= (op == OP_NOP);
        end
    end

    AST_FIRST_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ && idle_before) |=> !drive_q); // R6
    AST_READ_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ && !idle_before) |=> (drive_q && data_q == $past(rd_word))); // R2
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |=> !drive_q); // R7
endmodule

// File: rtl/pipe_sram.sv
// Top of the pipelined synchronous SRAM controller: input register, lane
// array, output register, and the asynchronous output-enable gate on dq.
// Assumes one command per clock; read latency is two rising edges.
module pipe_sram
    import pipe_sram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 2,
    parameter int LANE_DW = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           cs_a_n,
    input  logic                           cs_b,
    input  logic                           cs_c_n,
    input  logic                           glob_wr,
    input  logic                           lane_wr_en,
    input  logic [LANES-1:0]               lane_sel,
    input  logic [LANES*(LANE_DW+1)-1:0]   wdata,
    input  logic                           oe_n,
    output logic [LANES*(LANE_DW+1)-1:0]   dq
);
    localparam int LANE_W = LANE_DW + 1;
    localparam int WORD_W = LANES * LANE_W;

    sram_op_e           op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [WORD_W-1:0]  wdata_q;
    logic [LANES-1:0]   lane_we_q;
    logic [WORD_W-1:0]  rd_word;
    logic [WORD_W-1:0]  data_q;
    logic               drive_q;
    logic               chip_on;

    // All three chip selects must be in their active state.
    assign chip_on = !cs_a_n && cs_b && !cs_c_n;

    pipe_sram_capture #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .chip_on    (chip_on),
        .glob_wr    (glob_wr),
        .lane_wr_en (lane_wr_en),
        .lane_sel   (lane_sel),
        .wdata      (wdata),
        .op_q       (op_q),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .lane_we_q  (lane_we_q)
    );

    pipe_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .op      (op_q),
        .addr    (addr_q),
        .wdata   (wdata_q),
        .lane_we (lane_we_q),
        .rd_word (rd_word)
    );

    pipe_sram_outreg #(.WORD_W(WORD_W)) u_outreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op_q),
        .rd_word (rd_word),
        .data_q  (data_q),
        .drive_q (drive_q)
    );

    // Asynchronous output enable gates the registered data onto dq.
    assign dq = (drive_q && !oe_n) ? data_q : {WORD_W{1'bz}};

    AST_DESELECT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_on |-> ##2 !drive_q); // R3
    AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_on && glob_wr) |=> (lane_we_q == {LANES{1'b1}})); // R4
    AST_LANE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_on && !glob_wr && lane_wr_en) |=> (lane_we_q == $past(lane_sel))); // R1
endmodule

// File: tb/pipe_sram_tb.sv
// Self-checking bench: behavioural reference model updated on every rising
// edge, compared with dq on every falling edge.
module pipe_sram_tb;
    localparam int AW = 6;
    localparam int NL = 2;
    localparam int WW = 18;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          cs_a_n = 1'b1, cs_b = 1'b0, cs_c_n = 1'b1;
    logic          glob_wr = 1'b0, lane_wr_en = 1'b0;
    logic [NL-1:0] lane_sel = '0;
    logic [WW-1:0] wdata = '0;
    logic          oe_n = 1'b0;
    logic [WW-1:0] dq;

    int n_checks = 0;
    int n_fails  = 0;
    string tag = "R8";

    // Reference model state.
    logic [WW-1:0] ref_mem [DEPTH];
    bit            m_sel = 0, m_wr = 0, m_after = 1;
    logic [NL-1:0] m_lanes = '0;
    logic [AW-1:0] m_addr = '0;
    logic [WW-1:0] m_wdata = '0;
    bit            exp_drv = 0;
    logic [WW-1:0] exp_data = '0;

    always #4 clk = ~clk;

    pipe_sram #(.ADDR_W(AW), .LANES(NL), .LANE_DW(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs_a_n(cs_a_n), .cs_b(cs_b),
        .cs_c_n(cs_c_n), .glob_wr(glob_wr), .lane_wr_en(lane_wr_en),
        .lane_sel(lane_sel), .wdata(wdata), .oe_n(oe_n), .dq(dq)
    );

    // Model: execute the command captured last edge, then capture the new one.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_after = 1; exp_drv = 0;
        end else begin
            if (m_sel && m_wr) begin
                for (int l = 0; l < NL; l++)
                    if (m_lanes[l]) ref_mem[m_addr][l*9 +: 9] = m_wdata[l*9 +: 9];
            end
            exp_drv = m_sel && !m_wr && !m_after;
            if (m_sel && !m_wr) exp_data = ref_mem[m_addr];
            m_after = !m_sel;
            m_sel   = !cs_a_n && cs_b && !cs_c_n;
            m_wr    = glob_wr || lane_wr_en;
            m_lanes = glob_wr ? '1 : (lane_wr_en ? lane_sel : '0);
            m_addr  = addr;
            m_wdata = wdata;
        end
    end

    task automatic check_dq();
        logic [WW-1:0] exp;
        exp = (exp_drv && !oe_n) ? exp_data : {WW{1'bz}};
        n_checks++;
        if (dq !== exp) begin
            n_fails++;
            $display("FAIL %s: dq=%h expected=%h at %0t", tag, dq, exp, $time);
        end
    endtask

    // Drive one cycle's inputs, then compare after the next falling edge.
    task automatic cyc(input bit cs_ok, input bit gw, input bit bwe,
                       input logic [NL-1:0] sel, input logic [AW-1:0] a,
                       input logic [WW-1:0] d, input bit oen);
        cs_a_n = !cs_ok; cs_b = 1'b1; cs_c_n = 1'b0;
        glob_wr = gw; lane_wr_en = bwe; lane_sel = sel;
        addr = a; wdata = d; oe_n = oen;
        @(negedge clk);
        check_dq();
    endtask

    task automatic rd(input logic [AW-1:0] a);
        cyc(1, 0, 0, '0, a, '0, 0);
    endtask

    task automatic desel(input int which);
        cyc(1, 0, 0, '0, '0, '0, 0);
        @(posedge clk); // undo the selected command by redriving before capture is impossible; instead drive below
    endtask

    // Deselect one cycle by dropping a single chip select (which: 0,1,2), with a write attempt.
    task automatic drop_cs(input int which, input logic [AW-1:0] a, input logic [WW-1:0] d);
        glob_wr = 1; lane_wr_en = 0; lane_sel = '0; addr = a; wdata = d; oe_n = 0;
        cs_a_n = (which == 0); cs_b = (which != 1); cs_c_n = (which == 2);
        @(negedge clk);
        check_dq();
    endtask

    initial begin
        @(negedge clk);
        check_dq();                               // R8 reset output floats
        @(negedge clk);
        rst_n = 1'b1;
        check_dq();                               // R8

        tag = "R4";                               // fill every word via global write
        for (int i = 0; i < DEPTH; i++)
            cyc(1, 1, i[0], i[1:0], AW'(i), WW'(i * 1031 + 7), 0);

        tag = "R6";                               // first read after writes is driven (no deselect)
        drop_cs(1, 6'd3, 18'h3ffff);              // R3 deselect, write attempt via cs_b
        rd(6'd3);                                 // R6 first read after deselect masked
        tag = "R2";
        rd(6'd4); rd(6'd5); rd(6'd6);             // R2 consecutive reads driven
        tag = "R3";
        drop_cs(0, 6'd4, 18'h12345);
        drop_cs(2, 6'd5, 18'h23456);
        rd(6'd0); rd(6'd4); rd(6'd5);             // R3 no write happened, R6 first masked

        tag = "R5";                               // output enable acts with no clock edge
        oe_n = 1'b1; #1; check_dq();
        oe_n = 1'b0; #1; check_dq();
        cyc(1, 0, 0, '0, 6'd7, '0, 1);            // R5 read with oe_n high floats
        rd(6'd7);

        tag = "R1";                               // lane-selective writes
        cyc(1, 0, 1, 2'b01, 6'd10, 18'h2aaaa, 0);
        cyc(1, 0, 1, 2'b10, 6'd11, 18'h15555, 0);
        cyc(1, 0, 1, 2'b00, 6'd12, 18'h3ffff, 0);
        cyc(1, 0, 0, 2'b11, 6'd13, 18'h3ffff, 0); // R1 bwe low with selects set is a read
        tag = "R7";
        cyc(1, 1, 0, '0, 6'd14, 18'h00f0f, 0);    // R7 write cycle not driven
        tag = "R1";
        rd(6'd10); rd(6'd11); rd(6'd12); rd(6'd13);

        tag = "R9";                               // read right after write, same address
        cyc(1, 0, 1, 2'b11, 6'd20, 18'h0beef, 0);
        rd(6'd20); rd(6'd20);
        cyc(1, 1, 0, 2'b00, 6'd20, 18'h1cafe, 0);
        rd(6'd20); rd(6'd21);

        tag = "R2";                               // random mix of all command kinds
        for (int i = 0; i < 400; i++) begin
            int k;
            k = int'($urandom_range(0, 9));
            if (k == 0) drop_cs(int'($urandom_range(0, 2)), AW'($urandom), WW'($urandom));
            else if (k < 3) cyc(1, k == 1, 1, NL'($urandom), AW'($urandom), WW'($urandom), 0);
            else cyc(1, 0, 0, '0, AW'($urandom), '0, $urandom_range(0, 7) == 0);
        end

        tag = "R8";                               // reset in mid-traffic floats dq again
        rd(6'd1);
        rst_n = 1'b0;
        @(negedge clk); check_dq();
        rst_n = 1'b1;
        rd(6'd1);                                 // R8 first read after reset masked
        rd(6'd2);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_fails++;
        $display("FAIL watchdog: run did not complete, expected end before %0t", $time);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule